// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the part of a processor core that redirects control flow when an exception is taken, and that restores it on the matching return. For an entry request it receives a class code, a small reason code, the faulting program counter and the current machine state word. From these it computes four things: the return address and the saved state, the save slot that receives them (a standard slot or a hypervisor slot), the next machine state, and the handler address. The handler address comes from a per-class vector table, ORed with a base prefix and an optional relocation offset.

For a return request it reloads the program counter and machine state from the chosen save slot and cleans them up for execution. Each request completes in one clock cycle. A one-cycle `taken` pulse marks a redirect and a one-cycle `err` pulse marks a rejected entry. A machine check that arrives while machine checks are disabled puts the core into a sticky halted state.

Machine state bit positions used here, counting from bit 0 as the least significant bit:

| Bit | Meaning |
|-----|---------|
| 63 | 64-bit mode |
| 60 | hypervisor |
| 18 | power-save |
| 13 | FP enable |
| 12 | machine-check enable |
| 11 | FP mode 0 |
| 8 | FP mode 1 |
| 5 | instruction translation |
| 4 | data translation |
| 1 | recoverable |

Class codes:

| Code | Class |
|------|-------|
| 1 | machine check |
| 2 | data storage |
| 3 | external |
| 4 | program |
| 5 | system call |
| 6 | decrementer |
| 7 | hypervisor decrementer |
| 8 | hypervisor storage |
| 9 | emulation assist |
| 10 | trace |

Top module: `exc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero, including `taken`, `err`, `checkstop`, and all save slot, program counter and state outputs.
- R2: An accepted entry stores a return address and a saved state in one save slot. The return address is `ent_pc`, or `ent_pc`+4 for class 5. The saved state is `ent_msr` with the bits of mask 0x783F0000 cleared. Classes 7, 8 and 9 write the hypervisor slot (`hv_pc`/`hv_msr`). All other classes write the standard slot (`std_pc`/`std_msr`), and the slot not chosen keeps its value.
- R3: For class 4, the saved state also gets one reason bit set, selected by `ent_reason`: 0 sets 0x00100000 (FP fault), 1 sets 0x00080000 (illegal instruction), 2 sets 0x00040000 (privileged) and 3 sets 0x00020000 (trap).
- R4: A class 4 entry with reason 0 is dropped when FP mode bits 11 and 8 are both zero or FP enable bit 13 is zero. A dropped entry gives no `taken` and no `err`, and changes no save slot or output.
- R5: The next state keeps only bits 12 and 60 of `ent_msr`. Classes 7, 8 and 9 set bit 60 and copy bit 1 from `ent_msr`. Class 5 with reason 1 sets bit 60.
- R6: Class 1 clears bit 12 in the next state. If bit 12 of `ent_msr` is already zero, the entry is still made and `checkstop` rises with it. From then on `checkstop` stays high and every entry and return request is ignored.
- R7: The handler address is the class's vector table entry ORed with `vec_prefix`. An unknown class (0 or 11 to 15), or a table entry that is all ones, gives a single-cycle `err` pulse with no `taken` and no state change.
- R8: `reloc_mode` 2 ORs 0x18000 into the handler and mode 3 ORs 0xC000000000004000. Either mode also sets bits 5 and 4 of the next state. Relocation is skipped when bit 5 or bit 4 of `ent_msr` is zero, or when the next state has bit 60 set while `ent_msr` does not. Modes 0 and 1 never relocate.
- R9: A return reloads from the hypervisor slot when `ret_hv` is 1, otherwise from the standard slot. With `ret_wide` 0, only the low 32 bits of the saved state are used. Bit 18 of the restored state is cleared and the low two bits of the return address are forced to zero. The address's upper 32 bits are cleared when bit 63 of the restored state is zero.
- R10: `pc_out` and `msr_out` change only together with a one-cycle `taken` pulse, one clock edge after the request. When an entry and a return are requested in the same cycle, the entry is served and the return is dropped.
- R11: A write on `vec_we` replaces the table entry at `vec_waddr`, and later entries of that class use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| vec_we | input | 1 | vector table write enable |
| vec_waddr | input | 4 | vector table write index (class code) |
| vec_wdata | input | 64 | vector table write data |
| vec_prefix | input | 64 | base prefix ORed into every handler address |
| reloc_mode | input | 2 | relocation offset select |
| ent_valid | input | 1 | entry request |
| ent_class | input | 4 | exception class code |
| ent_reason | input | 2 | program reason or system call level |
| ent_pc | input | 64 | program counter at the exception |
| ent_msr | input | 64 | machine state at the exception |
| ret_valid | input | 1 | return request |
| ret_hv | input | 1 | return from the hypervisor slot |
| ret_wide | input | 1 | use all 64 bits of the saved state |
| taken | output | 1 | redirect pulse |
| err | output | 1 | rejected entry pulse |
| checkstop | output | 1 | sticky halted state |
| pc_out | output | 64 | new program counter |
| msr_out | output | 64 | new machine state |
| std_pc | output | 64 | standard slot return address |
| std_msr | output | 64 | standard slot saved state |
| hv_pc | output | 64 | hypervisor slot return address |
| hv_msr | output | 64 | hypervisor slot saved state |

## Verification
The assertions take three things for granted. First, every table entry an entry request reads has been written, because the table has no reset and an unwritten entry would make `taken` and `err` unknown. Second, the request inputs are low during reset. Third, each request lasts a single cycle.

The stimulus meets these conditions. It fills all sixteen table entries before the first request, holds all inputs low through reset, and raises each request at a falling edge for exactly one cycle, followed by an idle cycle. Entry and return requests are only combined in the one case that checks which of them wins.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 64;

  localparam int B_SF   = 63;
  localparam int B_HV   = 60;
  localparam int B_POW  = 18;
  localparam int B_FP   = 13;
  localparam int B_ME   = 12;
  localparam int B_FE0  = 11;
  localparam int B_FE1  = 8;
  localparam int B_IR   = 5;
  localparam int B_DR   = 4;
  localparam int B_RI   = 1;

  localparam logic [XLEN-1:0] SAVE_CLR_MASK = 64'h0000_0000_783F_0000;
  localparam logic [XLEN-1:0] RELOC_LOW     = 64'h0000_0000_0001_8000;
  localparam logic [XLEN-1:0] RELOC_HIGH    = 64'hC000_0000_0000_4000;

  typedef enum logic [3:0] {
    EXC_MCHECK = 4'd1,
    EXC_DSTOR  = 4'd2,
    EXC_EXT    = 4'd3,
    EXC_PROG   = 4'd4,
    EXC_SCALL  = 4'd5,
    EXC_DECR   = 4'd6,
    EXC_HDECR  = 4'd7,
    EXC_HDSTOR = 4'd8,
    EXC_HEMU   = 4'd9,
    EXC_TRACE  = 4'd10
  } exc_class_e;

  function automatic logic class_known(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd10);
  endfunction

  function automatic logic class_hyper(input logic [3:0] c);
    return (c == EXC_HDECR) || (c == EXC_HDSTOR) || (c == EXC_HEMU);
  endfunction
endpackage

// File: rtl/exc_vector_table.sv
module exc_vector_table #(
  parameter int DEPTH = 16,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int CLS_W = 4,
  parameter int RSN_W = 2
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [RSN_W-1:0] reason,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  msr,
  input  logic [XLEN-1:0]  vec,
  input  logic [XLEN-1:0]  prefix,
  input  logic [1:0]       reloc_mode,
  output logic             go,
  output logic             bad,
  output logic             use_hv,
  output logic             stop,
  output logic [XLEN-1:0]  save_pc,
  output logic [XLEN-1:0]  save_msr,
  output logic [XLEN-1:0]  next_msr,
  output logic [XLEN-1:0]  handler
);
  logic known, fp_drop, vec_miss, reloc_ok;
  logic [XLEN-1:0] nm;

  always_comb begin
    known    = class_known(cls);
    use_hv   = class_hyper(cls);
    fp_drop  = (cls == EXC_PROG) && (reason == '0) &&
               ((!msr[B_FE0] && !msr[B_FE1]) || !msr[B_FP]);
    vec_miss = &vec;
    bad      = !known || (!fp_drop && vec_miss);
    go       = known && !fp_drop && !vec_miss;
    stop     = (cls == EXC_MCHECK) && !msr[B_ME];

    save_pc  = (cls == EXC_SCALL) ? pc + XLEN'(4) : pc;
    save_msr = msr & ~SAVE_CLR_MASK;
    if (cls == EXC_PROG) begin
      unique case (reason[1:0])
        2'd0: save_msr[20] = 1'b1;
        2'd1: save_msr[19] = 1'b1;
        2'd2: save_msr[18] = 1'b1;
        default: save_msr[17] = 1'b1;
      endcase
    end

    nm = '0;
    nm[B_ME] = msr[B_ME];
    nm[B_HV] = msr[B_HV];
    if (use_hv) begin
      nm[B_HV] = 1'b1;
      nm[B_RI] = msr[B_RI];
    end
    if ((cls == EXC_SCALL) && (reason == RSN_W'(1))) nm[B_HV] = 1'b1;
    if (cls == EXC_MCHECK) nm[B_ME] = 1'b0;

    reloc_ok = msr[B_IR] && msr[B_DR] && !(nm[B_HV] && !msr[B_HV]);
    handler  = vec | prefix;
    if (reloc_ok && reloc_mode[1]) begin
      handler = handler | (reloc_mode[0] ? RELOC_HIGH : RELOC_LOW);
      nm[B_IR] = 1'b1;
      nm[B_DR] = 1'b1;
    end
    next_msr = nm;
  end
endmodule

// File: rtl/exc_return_calc.sv
module exc_return_calc
  import exc_pkg::*;
(
  input  logic            sel_hv,
  input  logic            wide,
  input  logic [XLEN-1:0] std_pc,
  input  logic [XLEN-1:0] std_msr,
  input  logic [XLEN-1:0] hv_pc,
  input  logic [XLEN-1:0] hv_msr,
  output logic [XLEN-1:0] rpc,
  output logic [XLEN-1:0] rmsr
);
  localparam int HALF = XLEN / 2;
  logic [XLEN-1:0] sp, sm;

  always_comb begin
    sp = sel_hv ? hv_pc  : std_pc;
    sm = sel_hv ? hv_msr : std_msr;
    if (!wide) sm[XLEN-1:HALF] = '0;
    sm[B_POW] = 1'b0;
    rmsr = sm;
    rpc  = {sp[XLEN-1:2], 2'b00};
    if (!sm[B_SF]) rpc[XLEN-1:HALF] = '0;
  end
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_pkg::*;
#(
  parameter int CLS_W = 4,
  parameter int RSN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vec_we,
  input  logic [CLS_W-1:0] vec_waddr,
  input  logic [XLEN-1:0]  vec_wdata,
  input  logic [XLEN-1:0]  vec_prefix,
  input  logic [1:0]       reloc_mode,
  input  logic             ent_valid,
  input  logic [CLS_W-1:0] ent_class,
  input  logic [RSN_W-1:0] ent_reason,
  input  logic [XLEN-1:0]  ent_pc,
  input  logic [XLEN-1:0]  ent_msr,
  input  logic             ret_valid,
  input  logic             ret_hv,
  input  logic             ret_wide,
  output logic             taken,
  output logic             err,
  output logic             checkstop,
  output logic [XLEN-1:0]  pc_out,
  output logic [XLEN-1:0]  msr_out,
  output logic [XLEN-1:0]  std_pc,
  output logic [XLEN-1:0]  std_msr,
  output logic [XLEN-1:0]  hv_pc,
  output logic [XLEN-1:0]  hv_msr
);
  localparam int NCLASS = 1 << CLS_W;

  logic [XLEN-1:0] vec_rd;
  logic            e_go, e_bad, e_hv, e_stop;
  logic [XLEN-1:0] e_spc, e_smsr, e_nmsr, e_handler;
  logic [XLEN-1:0] r_pc, r_msr;

  exc_vector_table #(.DEPTH(NCLASS), .DW(XLEN)) u_vtab (
    .clk(clk), .we(vec_we), .waddr(vec_waddr), .wdata(vec_wdata),
    .raddr(ent_class), .rdata(vec_rd)
  );

  exc_entry_calc #(.CLS_W(CLS_W), .RSN_W(RSN_W)) u_entry (
    .cls(ent_class), .reason(ent_reason), .pc(ent_pc), .msr(ent_msr),
    .vec(vec_rd), .prefix(vec_prefix), .reloc_mode(reloc_mode),
    .go(e_go), .bad(e_bad), .use_hv(e_hv), .stop(e_stop),
    .save_pc(e_spc), .save_msr(e_smsr), .next_msr(e_nmsr), .handler(e_handler)
  );

  exc_return_calc u_ret (
    .sel_hv(ret_hv), .wide(ret_wide),
    .std_pc(std_pc), .std_msr(std_msr), .hv_pc(hv_pc), .hv_msr(hv_msr),
    .rpc(r_pc), .rmsr(r_msr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken     <= 1'b0;
      err       <= 1'b0;
      checkstop <= 1'b0;
      pc_out    <= '0;
      msr_out   <= '0;
      std_pc    <= '0;
      std_msr   <= '0;
      hv_pc     <= '0;
      hv_msr    <= '0;
    end else begin
      taken <= 1'b0;
      err   <= 1'b0;
      if (!checkstop) begin
        if (ent_valid) begin
          if (e_go) begin
            taken   <= 1'b1;
            pc_out  <= e_handler;
            msr_out <= e_nmsr;
            if (e_hv) begin
              hv_pc  <= e_spc;
              hv_msr <= e_smsr;
            end else begin
              std_pc  <= e_spc;
              std_msr <= e_smsr;
            end
            if (e_stop) checkstop <= 1'b1;
          end else if (e_bad) begin
            err <= 1'b1;
          end
        end else if (ret_valid) begin
          taken   <= 1'b1;
          pc_out  <= r_pc;
          msr_out <= r_msr;
        end
      end
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(taken && err));

  p_cause_r10: assert property (@(posedge clk) disable iff (rst)
    taken |-> $past(ent_valid || ret_valid));

  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> (checkstop && !taken && !err));

  p_mchk_me_r6: assert property (@(posedge clk) disable iff (rst)
    (taken && $past(ent_valid && ent_class == EXC_MCHECK)) |-> !msr_out[B_ME]);

  p_hv_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(ent_valid) |-> ($stable(hv_pc) && $stable(hv_msr)));

  p_ret_align_r9: assert property (@(posedge clk) disable iff (rst)
    (taken && $past(ret_valid && !ent_valid)) |-> (pc_out[1:0] == 2'b00));
endmodule

// File: tb/exc_sequencer_bench.sv
`timescale 1ns/1ps
module exc_sequencer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vec_we = 0;
  logic [3:0] vec_waddr = 0;
  logic [63:0] vec_wdata = 0, vec_prefix = 0;
  logic [1:0] reloc_mode = 0;
  logic ent_valid = 0;
  logic [3:0] ent_class = 0;
  logic [1:0] ent_reason = 0;
  logic [63:0] ent_pc = 0, ent_msr = 0;
  logic ret_valid = 0, ret_hv = 0, ret_wide = 0;
  logic taken, err, checkstop;
  logic [63:0] pc_out, msr_out, std_pc, std_msr, hv_pc, hv_msr;

  always #2.5 clk = ~clk;

  exc_sequencer u_exc_sequencer (
    .clk(clk), .rst(rst), .vec_we(vec_we), .vec_waddr(vec_waddr),
    .vec_wdata(vec_wdata), .vec_prefix(vec_prefix), .reloc_mode(reloc_mode),
    .ent_valid(ent_valid), .ent_class(ent_class), .ent_reason(ent_reason),
    .ent_pc(ent_pc), .ent_msr(ent_msr), .ret_valid(ret_valid),
    .ret_hv(ret_hv), .ret_wide(ret_wide), .taken(taken), .err(err),
    .checkstop(checkstop), .pc_out(pc_out), .msr_out(msr_out),
    .std_pc(std_pc), .std_msr(std_msr), .hv_pc(hv_pc), .hv_msr(hv_msr)
  );

  typedef struct {
    string tag;
    logic taken, err, cs;
    logic [63:0] pc, msr, sp, sm, hp, hm;
  } exp_t;
  exp_t q[$];

  int n_run = 0, n_fail = 0;
  logic [63:0] mv [16];
  logic [63:0] m_pc = 0, m_msr = 0, m_sp = 0, m_sm = 0, m_hp = 0, m_hm = 0;
  logic m_cs = 0;

  localparam logic [63:0] ME = 64'h1 << 12, HV = 64'h1 << 60, RI = 64'h2;
  localparam logic [63:0] IRDR = 64'h30, SF = 64'h1 << 63;
  localparam logic [63:0] FPEN = (64'h1 << 13) | (64'h1 << 11);

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (taken !== e.taken || err !== e.err || checkstop !== e.cs ||
          pc_out !== e.pc || msr_out !== e.msr || std_pc !== e.sp ||
          std_msr !== e.sm || hv_pc !== e.hp || hv_msr !== e.hm) begin
        n_fail++;
        $display("FAIL %s: taken %b/%b err %b/%b cs %b/%b pc %h/%h msr %h/%h std %h,%h/%h,%h hv %h,%h/%h,%h",
          e.tag, taken, e.taken, err, e.err, checkstop, e.cs, pc_out, e.pc,
          msr_out, e.msr, std_pc, std_msr, e.sp, e.sm, hv_pc, hv_msr, e.hp, e.hm);
      end
    end
  end

  task automatic write_vec(input int idx, input logic [63:0] val);
    @(negedge clk);
    vec_we = 1; vec_waddr = 4'(idx); vec_wdata = val; mv[idx] = val;
    @(negedge clk);
    vec_we = 0;
  endtask

  task automatic req(input string tag, input bit ev, input logic [3:0] c,
                     input logic [1:0] r, input logic [63:0] pc,
                     input logic [63:0] msr, input bit rv, input bit rhv,
                     input bit rwide);
    exp_t e;
    logic [63:0] v, nm, h, sm, sp;
    bit drop;
    @(negedge clk);
    ent_valid = ev; ent_class = c; ent_reason = r; ent_pc = pc; ent_msr = msr;
    ret_valid = rv; ret_hv = rhv; ret_wide = rwide;
    e.taken = 0; e.err = 0;
    if (!m_cs) begin
      if (ev) begin
        drop = (c == 4) && (r == 0) && ((!msr[11] && !msr[8]) || !msr[13]);
        v = mv[c];
        if (!(c inside {[1:10]}) || (!drop && v == '1)) e.err = 1;
        else if (!drop) begin
          sp = (c == 5) ? pc + 4 : pc;
          sm = msr & ~64'h783F0000;
          if (c == 4) sm = sm | (64'h0010_0000 >> r);
          nm = msr & (ME | HV);
          if (c inside {7, 8, 9}) nm = nm | HV | (msr & RI);
          if (c == 5 && r == 1) nm = nm | HV;
          if (c == 1) nm = nm & ~ME;
          h = v | vec_prefix;
          if (msr[5] && msr[4] && !(nm[60] && !msr[60]) && reloc_mode[1]) begin
            h = h | (reloc_mode[0] ? 64'hC000_0000_0000_4000 : 64'h18000);
            nm = nm | IRDR;
          end
          if (c == 1 && !msr[12]) m_cs = 1;
          if (c inside {7, 8, 9}) begin m_hp = sp; m_hm = sm; end
          else begin m_sp = sp; m_sm = sm; end
          m_pc = h; m_msr = nm; e.taken = 1;
        end
      end else if (rv) begin
        sm = rhv ? m_hm : m_sm;
        sp = rhv ? m_hp : m_sp;
        if (!rwide) sm[63:32] = 0;
        sm[18] = 0;
        sp[1:0] = 0;
        if (!sm[63]) sp[63:32] = 0;
        m_pc = sp; m_msr = sm; e.taken = 1;
      end
    end
    e.tag = tag; e.cs = m_cs; e.pc = m_pc; e.msr = m_msr;
    e.sp = m_sp; e.sm = m_sm; e.hp = m_hp; e.hm = m_hm;
    q.push_back(e);
    @(negedge clk);
    ent_valid = 0; ret_valid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: expired, actual hung, expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    n_run++;
    if (taken !== 0 || err !== 0 || checkstop !== 0 || pc_out !== 0 ||
        msr_out !== 0 || std_pc !== 0 || std_msr !== 0 || hv_pc !== 0 || hv_msr !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: taken %b err %b pc %h, expected all zero", taken, err, pc_out);
    end
    rst = 0;
    for (int i = 0; i < 16; i++) write_vec(i, (i == 6) ? '1 : 64'(i) << 8);

    req("R2 data storage std slot", 1, 2, 0, 64'h1000_2000, 64'h7FFF_F000 | ME | (1 << 15), 0, 0, 0);
    req("R3 program FP reason", 1, 4, 0, 64'h40, FPEN, 0, 0, 0);
    req("R3 program illegal", 1, 4, 1, 64'h44, 0, 0, 0, 0);
    req("R3 program privileged", 1, 4, 2, 64'h48, SF | ME, 0, 0, 0);
    req("R3 program trap", 1, 4, 3, 64'h4C, 0, 0, 0, 0);
    req("R4 FP drop modes off", 1, 4, 0, 64'h50, 64'h1 << 13, 0, 0, 0);
    req("R4 FP drop FP disabled", 1, 4, 0, 64'h54, 64'h1 << 11, 0, 0, 0);
    req("R5 syscall level 0", 1, 5, 0, 64'h200, ME, 0, 0, 0);
    req("R5 syscall level 1", 1, 5, 1, 64'h300, 0, 0, 0, 0);
    req("R5 hyper decrementer", 1, 7, 0, 64'h400, RI | ME, 0, 0, 0);
    req("R2 emulation assist hv slot", 1, 9, 0, 64'h504, HV, 0, 0, 0);
    req("R9 return hv slot", 0, 0, 0, 0, 0, 1, 1, 1);
    req("R6 machine check clears ME", 1, 1, 0, 64'h600, ME | HV, 0, 0, 0);
    req("R7 unknown class 12", 1, 12, 0, 64'h700, 0, 0, 0, 0);
    req("R7 unknown class 0", 1, 0, 0, 64'h704, 0, 0, 0, 0);
    req("R7 missing vector", 1, 6, 0, 64'h708, 0, 0, 0, 0);
    @(negedge clk); vec_prefix = 64'hFFF0_0000; reloc_mode = 2;
    req("R8 reloc mode 2 and prefix", 1, 2, 0, 64'h800, IRDR, 0, 0, 0);
    @(negedge clk); reloc_mode = 3;
    req("R8 reloc mode 3", 1, 3, 0, 64'h804, IRDR | ME, 0, 0, 0);
    req("R8 reloc off translation off", 1, 3, 0, 64'h808, 64'h20, 0, 0, 0);
    req("R8 reloc off entering hv", 1, 8, 0, 64'h80C, IRDR, 0, 0, 0);
    req("R8 reloc kept already hv", 1, 8, 0, 64'h810, IRDR | HV, 0, 0, 0);
    @(negedge clk); reloc_mode = 0; vec_prefix = 0;
    req("R3 privileged with 64-bit state", 1, 4, 2, 64'hFFFF_0000_1234_5677, SF | ME, 0, 0, 0);
    req("R9 wide return clears POW", 0, 0, 0, 0, 0, 1, 0, 1);
    req("R9 narrow return truncates", 0, 0, 0, 0, 0, 1, 0, 0);
    req("R10 entry wins over return", 1, 10, 0, 64'h900, 0, 1, 0, 1);
    write_vec(10, 64'hABC0);
    req("R11 rewritten vector", 1, 10, 0, 64'h904, 0, 0, 0, 0);
    req("R6 machine check with ME off", 1, 1, 0, 64'hA00, 0, 0, 0, 0);
    req("R6 entry ignored in checkstop", 1, 2, 0, 64'hA04, ME, 0, 0, 0);
    req("R6 return ignored in checkstop", 0, 0, 0, 0, 0, 1, 0, 1);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule